// File: doc/BRIEF.md
# Full-Frame CCD Readout Clock Sequencer

This block produces the digital phase pattern that reads a two-phase full-frame CCD through a single serial register. While charge integrates, it holds the array clocks quiet. On a readout command it walks the frame line by line. For each line it runs a three-interval accumulation-mode parallel shift, waits a horizontal setup interval, and then clocks the serial register pixel by pixel. The last serial gate is split in two halves, and the block steers it so that the packets land on either the low-gain or the high-gain output node.

For a downstream converter, the block emits a reset-level and a video-level sample strobe in every counted pixel, together with a region tag and a dark-line flag. The reset clock runs in every pixel period, including when no readout is in progress. All interval lengths and the gain choice are captured when a frame starts. The array and line geometry are parameters.

Top module: `ccd_readout_seq`

## Requirements
- R1: Out of readout (integration state), the parallel phases `v1_o` and `v2_o` are both 0, `h1_o` is 1, `h2_o` is 0, and no strobe, tag, dark flag or done pulse is driven. The block stays in this state until `start_i` is seen high.
- R2: Every line begins with three parallel intervals in a fixed order, each `tv_i` clocks long: (`v1_o`=1, `v2_o`=0), then (0,1), then (1,0). A value of 0 counts as 1. The first interval starts in the clock after `start_i` is accepted, or in the clock after the previous line ends.
- R3: After the third parallel interval, a setup interval of `ths_i` clocks (0 counts as 1) follows with both parallel phases 0 and the serial clocks idle. Serial clocking starts directly after it.
- R4: During serial clocking, `h1_o` is always the inverse of `h2_o`. A pixel period is 2·`half_i` clocks, with `h2_o` high for the first `half_i` clocks. A line carries exactly N+1 periods, where N is the number of counted pixels (530 by default), so a line lasts 3·tV + tHS + (N+1)·2·`half_i` clocks.
- R5: `r_o` is high for the first `rw_i` clocks of every pixel period (1 ≤ `rw_i` < `half_i`), with no gap in any state. Pixel periods in the parallel and setup intervals run from the start of the line. A new period starts at the first serial clock and again after a frame start.
- R6: `gain_hi_i` is sampled only when a frame starts. When it is 0, `h21_o` follows `h2_o` and `h22_o` stays 0. When it is 1, `h22_o` follows `h2_o` and `h21_o` stays 0. A change of `gain_hi_i` during a frame has no effect on that frame.
- R7: In each of the N counted pixels, `rst_stb_o` pulses for one clock at phase `rw_i` (just after `r_o` falls). `vid_stb_o` pulses for one clock at phase 2·`half_i`−1, after `h2_o` has fallen. No strobe is driven in the extra period or outside serial clocking.
- R8: During serial clocking, `region_o` tags counted pixel k (from 1) as 1 = dummy for k 1–4 and 529–530, 2 = dark reference for k 5–8 and 521–528, and 3 = active for k 9–520. Otherwise `region_o` is 0. The segment sizes are parameters.
- R9: `dark_line_o` is 1 during serial clocking of the first and of the last `EDGE_LINES` lines of a frame (4 by default), and 0 otherwise.
- R10: A frame holds `LINES` lines (520 by default). `done_o` pulses for exactly one clock, in the first clock back in the integration state after the last line.
- R11: While a frame runs, `start_i` and any change of `tv_i`, `ths_i`, `half_i`, `rw_i` or `gain_hi_i` are ignored until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Readout request, accepted only in the integration state |
| gain_hi_i | input | 1 | Output node choice: 0 low gain, 1 high gain |
| tv_i | input | CNT_W | Parallel interval length in clocks |
| ths_i | input | CNT_W | Horizontal setup length in clocks |
| half_i | input | HALF_W | Half pixel period in clocks |
| rw_i | input | HALF_W | Reset clock pulse width in clocks |
| v1_o | output | 1 | Parallel phase 1 |
| v2_o | output | 1 | Parallel phase 2 |
| h1_o | output | 1 | Serial phase 1 |
| h2_o | output | 1 | Serial phase 2 |
| r_o | output | 1 | Output node reset clock |
| h21_o | output | 1 | Split last gate, low-gain side |
| h22_o | output | 1 | Split last gate, high-gain side |
| rst_stb_o | output | 1 | Reset-level sample strobe |
| vid_stb_o | output | 1 | Video-level sample strobe |
| region_o | output | 2 | Pixel tag: 0 none, 1 dummy, 2 dark, 3 active |
| dark_line_o | output | 1 | Current line is a dark line |
| done_o | output | 1 | One-clock frame completion pulse |

## Verification
A wrong sequencer state shows up at once as a bad `v1_o`/`v2_o` pair, often within one clock of an interval boundary. An interval counter that is off by one moves every later edge of the line and shifts the whole frame length, so `done_o` lands on the wrong clock. A pixel-phase or pixel-count error first shows as a misplaced strobe or region tag in the same line. A stale line count shows up only at the dark-line boundaries or at the end of the frame. For this reason, every output is compared on every clock against an arithmetic timeline over whole frames.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_VA     = 3'd1,
    ST_VB     = 3'd2,
    ST_VC     = 3'd3,
    ST_HSET   = 3'd4,
    ST_HSHIFT = 3'd5
  } seq_st_t;

  typedef enum logic [1:0] {
    RG_NONE   = 2'd0,
    RG_DUMMY  = 2'd1,
    RG_DARK   = 2'd2,
    RG_ACTIVE = 2'd3
  } region_t;

endpackage

// File: rtl/ccd_pix_timer.sv
module ccd_pix_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [HALF_W-1:0] rw_i,
  output logic              r_o,
  output logic              h2_lvl_o,
  output logic              rst_pt_o,
  output logic              vid_pt_o
);

  localparam int PH_W = HALF_W + 1;

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;
  logic [PH_W-1:0] period_w;
  logic            wrap;

  assign period_w = {half_i, 1'b0};
  assign wrap     = (ph_q == period_w - 1'b1);

  always_comb begin
    if (sync_i || wrap) ph_d = '0;
    else                ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign r_o      = (ph_q < {1'b0, rw_i});
  assign h2_lvl_o = (ph_q < {1'b0, half_i});
  assign rst_pt_o = (ph_q == {1'b0, rw_i});
  assign vid_pt_o = wrap;

  AST_PH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < period_w); // R4

endmodule

// File: rtl/ccd_line_fsm.sv
module ccd_line_fsm
  import ccd_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HALF_W   = 8,
  parameter int LINES    = 520,
  parameter int DEF_HALF = 4,
  parameter int DEF_RW   = 1,
  localparam int LINE_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              gain_i,
  input  logic [CNT_W-1:0]  tv_i,
  input  logic [CNT_W-1:0]  ths_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [HALF_W-1:0] rw_i,
  input  logic              pix_wrap_i,
  input  logic              last_pix_i,
  output seq_st_t           st_o,
  output logic [LINE_W-1:0] line_o,
  output logic              sync_o,
  output logic              done_o,
  output logic [HALF_W-1:0] half_o,
  output logic [HALF_W-1:0] rw_o,
  output logic              gain_o
);

  seq_st_t           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              done_q, done_d;
  logic              load_cfg;
  logic              sync_w;
  logic [CNT_W-1:0]  tv_q, ths_q;
  logic [HALF_W-1:0] half_q, rw_q;
  logic              gain_q;
  logic              cnt_zero;
  logic              last_line;

  function automatic logic [CNT_W-1:0] ival(input logic [CNT_W-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  assign cnt_zero  = (cnt_q == '0);
  assign last_line = (line_q == LINE_W'(LINES - 1));

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    line_d   = line_q;
    done_d   = 1'b0;
    load_cfg = 1'b0;
    sync_w   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_cfg = 1'b1;
          sync_w   = 1'b1;
          st_d     = ST_VA;
          cnt_d    = ival(tv_i);
          line_d   = '0;
        end
      end
      ST_VA: begin
        if (cnt_zero) begin
          st_d  = ST_VB;
          cnt_d = ival(tv_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_VB: begin
        if (cnt_zero) begin
          st_d  = ST_VC;
          cnt_d = ival(tv_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_VC: begin
        if (cnt_zero) begin
          st_d  = ST_HSET;
          cnt_d = ival(ths_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HSET: begin
        if (cnt_zero) begin
          st_d   = ST_HSHIFT;
          sync_w = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HSHIFT: begin
        if (pix_wrap_i && last_pix_i) begin
          if (last_line) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d   = ST_VA;
            line_d = line_q + 1'b1;
            cnt_d  = ival(tv_q);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      line_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      line_q <= line_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv_q   <= '0;
      ths_q  <= '0;
      half_q <= HALF_W'(DEF_HALF);
      rw_q   <= HALF_W'(DEF_RW);
      gain_q <= 1'b0;
    end else if (load_cfg) begin
      tv_q   <= tv_i;
      ths_q  <= ths_i;
      half_q <= half_i;
      rw_q   <= rw_i;
      gain_q <= gain_i;
    end
  end

  assign st_o   = st_q;
  assign line_o = line_q;
  assign sync_o = sync_w;
  assign done_o = done_q;
  assign half_o = half_q;
  assign rw_o   = rw_q;
  assign gain_o = gain_q;

  AST_VB_AFTER_VA: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VB && $past(st_q) != ST_VB) |-> $past(st_q) == ST_VA); // R2
  AST_VC_AFTER_VB: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VC && $past(st_q) != ST_VC) |-> $past(st_q) == ST_VB); // R2
  AST_SHIFT_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HSHIFT && $past(st_q) != ST_HSHIFT) |-> $past(st_q) == ST_HSET); // R3
  AST_GAIN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(gain_q)); // R6
  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(line_q) < LINES); // R10

endmodule

// File: rtl/ccd_pix_tagger.sv
module ccd_pix_tagger
  import ccd_seq_pkg::*;
#(
  parameter int LEAD_DUM   = 4,
  parameter int LEAD_DARK  = 4,
  parameter int ACTIVE     = 512,
  parameter int TRAIL_DARK = 8,
  parameter int TRAIL_DUM  = 2,
  parameter int LINES      = 520,
  parameter int EDGE_LINES = 4,
  parameter int LINE_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              shift_i,
  input  logic              wrap_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              last_pix_o,
  output logic              counted_o,
  output logic [1:0]        region_o,
  output logic              dark_line_o
);

  localparam int B1       = LEAD_DUM;
  localparam int B2       = B1 + LEAD_DARK;
  localparam int B3       = B2 + ACTIVE;
  localparam int B4       = B3 + TRAIL_DARK;
  localparam int LINE_PIX = B4 + TRAIL_DUM;
  localparam int PC_W     = $clog2(LINE_PIX + 1);
  localparam int NSEG     = 5;
  localparam int SEG_END [NSEG] = '{B1, B2, B3, B4, LINE_PIX};
  localparam region_t SEG_TAG [NSEG] = '{RG_DUMMY, RG_DARK, RG_ACTIVE, RG_DARK, RG_DUMMY};

  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;
  region_t         tag;

  assign pc_en = sync_i || (shift_i && wrap_i && (int'(pc_q) != LINE_PIX));

  always_comb begin
    if (sync_i) pc_d = '0;
    else        pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_comb begin
    tag = RG_NONE;
    for (int i = NSEG - 1; i >= 0; i--) begin
      if (int'(pc_q) < SEG_END[i]) tag = SEG_TAG[i];
    end
  end

  assign last_pix_o  = (int'(pc_q) == LINE_PIX);
  assign counted_o   = shift_i && (int'(pc_q) < LINE_PIX);
  assign region_o    = shift_i ? tag : RG_NONE;
  assign dark_line_o = shift_i &&
                       ((int'(line_i) < EDGE_LINES) || (int'(line_i) >= LINES - EDGE_LINES));

  AST_PC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pc_q) <= LINE_PIX); // R4
  AST_TAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |-> (region_o == RG_NONE && !dark_line_o)); // R8

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int HALF_W     = 8,
  parameter int LEAD_DUM   = 4,
  parameter int LEAD_DARK  = 4,
  parameter int ACTIVE     = 512,
  parameter int TRAIL_DARK = 8,
  parameter int TRAIL_DUM  = 2,
  parameter int LINES      = 520,
  parameter int EDGE_LINES = 4,
  parameter int DEF_HALF   = 4,
  parameter int DEF_RW     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              gain_hi_i,
  input  logic [CNT_W-1:0]  tv_i,
  input  logic [CNT_W-1:0]  ths_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [HALF_W-1:0] rw_i,
  output logic              v1_o,
  output logic              v2_o,
  output logic              h1_o,
  output logic              h2_o,
  output logic              r_o,
  output logic              h21_o,
  output logic              h22_o,
  output logic              rst_stb_o,
  output logic              vid_stb_o,
  output logic [1:0]        region_o,
  output logic              dark_line_o,
  output logic              done_o
);

  localparam int LINE_W = $clog2(LINES);

  logic              rs0_q, rs1_q;
  logic              rst_in_n;
  seq_st_t           st;
  logic [LINE_W-1:0] line;
  logic              sync;
  logic [HALF_W-1:0] half_q, rw_q;
  logic              gain_q;
  logic              h2_lvl, rst_pt, vid_pt;
  logic              last_pix, counted;
  logic              shift;
  logic [1:0]        tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_in_n = rs1_q;

  ccd_line_fsm #(
    .CNT_W(CNT_W), .HALF_W(HALF_W), .LINES(LINES),
    .DEF_HALF(DEF_HALF), .DEF_RW(DEF_RW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_in_n), .start_i(start_i), .gain_i(gain_hi_i),
    .tv_i(tv_i), .ths_i(ths_i), .half_i(half_i), .rw_i(rw_i),
    .pix_wrap_i(vid_pt), .last_pix_i(last_pix),
    .st_o(st), .line_o(line), .sync_o(sync), .done_o(done_o),
    .half_o(half_q), .rw_o(rw_q), .gain_o(gain_q)
  );

  ccd_pix_timer #(.HALF_W(HALF_W)) u_tim (
    .clk(clk), .rst_n(rst_in_n), .sync_i(sync), .half_i(half_q), .rw_i(rw_q),
    .r_o(r_o), .h2_lvl_o(h2_lvl), .rst_pt_o(rst_pt), .vid_pt_o(vid_pt)
  );

  ccd_pix_tagger #(
    .LEAD_DUM(LEAD_DUM), .LEAD_DARK(LEAD_DARK), .ACTIVE(ACTIVE),
    .TRAIL_DARK(TRAIL_DARK), .TRAIL_DUM(TRAIL_DUM), .LINES(LINES),
    .EDGE_LINES(EDGE_LINES), .LINE_W(LINE_W)
  ) u_tag (
    .clk(clk), .rst_n(rst_in_n), .sync_i(sync), .shift_i(shift), .wrap_i(vid_pt),
    .line_i(line), .last_pix_o(last_pix), .counted_o(counted),
    .region_o(region_o), .dark_line_o(dark_line_o)
  );

  assign shift = (st == ST_HSHIFT);
  assign v1_o  = (st == ST_VA) || (st == ST_VC);
  assign v2_o  = (st == ST_VB);
  assign h2_o  = shift && h2_lvl;
  assign h1_o  = !h2_o;

  for (genvar g = 0; g < 2; g++) begin : g_tap
    assign tap[g] = h2_o && (gain_q == 1'(g));
  end
  assign h21_o = tap[0];
  assign h22_o = tap[1];

  assign rst_stb_o = counted && rst_pt;
  assign vid_stb_o = counted && vid_pt;

  AST_VID_AFTER_H2: assert property (@(posedge clk) disable iff (!rst_in_n)
    vid_stb_o |-> (!h2_o && !r_o)); // R7
  AST_RST_AFTER_R: assert property (@(posedge clk) disable iff (!rst_in_n)
    rst_stb_o |-> $fell(r_o)); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_in_n)
    done_o |-> (!v1_o && !v2_o && h1_o && !rst_stb_o)); // R10
  AST_SPLIT_EXCL: assert property (@(posedge clk) disable iff (!rst_in_n)
    $onehot0({h21_o, h22_o, h1_o})); // R6

endmodule

// File: tb/sim_ccd_readout_seq.sv
module sim_ccd_readout_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int HALF_W = 4;
  localparam int LD = 1, LK = 1, AC = 3, TK = 2, TD = 1;
  localparam int LINES = 4, EDGE = 1;
  localparam int LP = LD + LK + AC + TK + TD;
  localparam int WD_CYCLES = 20000;

  logic clk, rst_n, start_i, gain_hi_i;
  logic [CNT_W-1:0]  tv_i, ths_i;
  logic [HALF_W-1:0] half_i, rw_i;
  logic v1_o, v2_o, h1_o, h2_o, r_o, h21_o, h22_o, rst_stb_o, vid_stb_o, dark_line_o, done_o;
  logic [1:0] region_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  ccd_readout_seq #(
    .CNT_W(CNT_W), .HALF_W(HALF_W), .LEAD_DUM(LD), .LEAD_DARK(LK), .ACTIVE(AC),
    .TRAIL_DARK(TK), .TRAIL_DUM(TD), .LINES(LINES), .EDGE_LINES(EDGE),
    .DEF_HALF(2), .DEF_RW(1)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .gain_hi_i(gain_hi_i),
    .tv_i(tv_i), .ths_i(ths_i), .half_i(half_i), .rw_i(rw_i),
    .v1_o(v1_o), .v2_o(v2_o), .h1_o(h1_o), .h2_o(h2_o), .r_o(r_o),
    .h21_o(h21_o), .h22_o(h22_o), .rst_stb_o(rst_stb_o), .vid_stb_o(vid_stb_o),
    .region_o(region_o), .dark_line_o(dark_line_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d time=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_region(input int pix);
    if (pix < LD)                return 1;
    if (pix < LD + LK)           return 2;
    if (pix < LD + LK + AC)      return 3;
    if (pix < LD + LK + AC + TK) return 2;
    if (pix < LP)                return 1;
    return 0;
  endfunction

  task automatic check_idle(input string req);
    chk(req, "v1 idle", int'(v1_o), 0);
    chk(req, "v2 idle", int'(v2_o), 0);
    chk(req, "h1 idle", int'(h1_o), 1);
    chk(req, "h2 idle", int'(h2_o), 0);
    chk(req, "strobes idle", int'(rst_stb_o) + int'(vid_stb_o), 0);
    chk(req, "region idle", int'(region_o), 0);
    chk(req, "dark idle", int'(dark_line_o), 0);
  endtask

  // Sweeps one full frame plus an idle tail and compares every output on every clock.
  task automatic run_frame(input int tv, input int ths, input int h, input int rw, input bit gain);
    int tve  = (tv < 1) ? 1 : tv;
    int thse = (ths < 1) ? 1 : ths;
    int lt   = 3 * tve + thse + (LP + 1) * 2 * h;
    int ft   = LINES * lt;
    @(negedge clk);
    tv_i = CNT_W'(tv); ths_i = CNT_W'(ths);
    half_i = HALF_W'(h); rw_i = HALF_W'(rw);
    gain_hi_i = gain; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < ft + 6 * h; k++) begin
      int line = 0, o = 0, ph = 0, pix = 0;
      bit sh = 0, v1e = 0, v2e = 0, h2e = 0, cnt = 0, dk = 0, de = 0;
      int rg = 0;
      string vtag;
      if (k < ft) begin
        line = k / lt;
        o    = k % lt;
        v1e  = (o < tve) || (o >= 2 * tve && o < 3 * tve);
        v2e  = (o >= tve) && (o < 2 * tve);
        sh   = (o >= 3 * tve + thse);
        if (sh) begin
          pix = (o - 3 * tve - thse) / (2 * h);
          ph  = (o - 3 * tve - thse) % (2 * h);
        end else begin
          ph = o % (2 * h);
        end
        h2e = sh && (ph < h);
        cnt = sh && (pix < LP);
        rg  = sh ? exp_region(pix) : 0;
        dk  = sh && ((line < EDGE) || (line >= LINES - EDGE));
        vtag = (o < 3 * tve) ? "R2" : (sh ? "R4" : "R3");
      end else begin
        ph   = (k - ft) % (2 * h);
        de   = (k == ft);
        vtag = "R1";
      end
      chk(vtag, "v1", int'(v1_o), int'(v1e));
      chk(vtag, "v2", int'(v2_o), int'(v2e));
      chk((k < ft && !sh) ? "R3" : "R4", "h2", int'(h2_o), int'(h2e));
      chk("R4", "h1 complement", int'(h1_o), int'(!h2e));
      chk("R5", "reset clock", int'(r_o), int'(ph < rw));
      chk("R6", "h21", int'(h21_o), gain ? 0 : int'(h2e));
      chk("R6", "h22", int'(h22_o), gain ? int'(h2e) : 0);
      chk("R7", "reset strobe", int'(rst_stb_o), int'(cnt && ph == rw));
      chk("R7", "video strobe", int'(vid_stb_o), int'(cnt && ph == 2 * h - 1));
      chk("R8", "region", int'(region_o), rg);
      chk("R9", "dark line", int'(dark_line_o), int'(dk));
      chk("R10", "done", int'(done_o), int'(de));
      if (k > lt + 3 && k < lt + 4 + 3 * tve + thse + 4 * h)
        chk("R11", "v1 after ignored start", int'(v1_o), int'(v1e));
      if (k == lt + 3) begin
        start_i = 1'b1; gain_hi_i = !gain;
        tv_i = CNT_W'(tv + 2); half_i = HALF_W'(h + 1);
      end
      if (k == lt + 4) start_i = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; gain_hi_i = 1'b0;
    tv_i = '0; ths_i = '0; half_i = 4'd2; rw_i = 4'd1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      check_idle("R1");
      chk("R10", "done at reset", int'(done_o), 0);
      @(negedge clk);
    end
    run_frame(3, 2, 2, 1, 1'b0);
    run_frame(1, 1, 3, 2, 1'b1);
    run_frame(0, 0, 2, 1, 1'b0);
    run_frame(4, 3, 4, 3, 1'b1);
    for (int i = 0; i < 8; i++) begin
      check_idle("R1");
      @(negedge clk);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule